// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Code Register

This block is the digital front end of a two-channel 12-bit converter fed from an 8-bit bus. Each channel's 12-bit code is written in two parts: a low byte and a high nibble. The two parts go into a pair of staging registers, one pair per channel. A separate transfer strobe then copies the staged codes of both channels into their output registers on the same clock edge, so the two channels can be changed together.

When the transfer strobe and a write occur together, the output registers become transparent: the byte being written goes straight through to the selected channel's output. An active-low wipe input clears every register at once. Its release is synchronised to the clock.

All strobes are active low and are sampled on the rising clock edge. The interface is plain strobes, not a valid/ready stream. There is no back-pressure: every qualified write is taken on the edge that samples it, and a write held over several edges simply stores the same value again. A one-cycle pulse marks each clock edge at which either output code takes a new value.

Top module: `twin_dac_loader`

## Requirements
- R1: The address picks the target of a write: 00 is channel A low byte, 01 is channel A high nibble, 10 is channel B low byte, 11 is channel B high nibble. A write reaches no other staging register.
- R2: With xfer_n high, the addressed staging register loads on a rising edge only when sel_n and wstb_n are both low. The output codes do not change.
- R3: With sel_n high and both xfer_n and wstb_n low, both output codes take their staged codes on the same edge.
- R4: With sel_n, wstb_n and xfer_n all low, the byte being written is staged and also reaches the selected channel's output code on that same edge. The other channel's output takes its own staged code.
- R5: While wipe_n is low, all staging registers and both output codes are zero at once, whatever the other inputs are. After wipe_n rises, the first two rising edges are ignored, and the third rising edge is the first one that can load.
- R6: With xfer_n high and either sel_n or wstb_n high, no register changes. xfer_n low while wstb_n is high also changes nothing.
- R7: An output code is {high nibble, low byte}, right-justified. During a high-nibble write, bus bits 7..4 are ignored and only bits 3..0 are stored.
- R8: out_changed is high for exactly the cycle in which a new value first appears on code_a or code_b. A transfer that rewrites an equal value gives no pulse.
- R9: Holding a write for several edges leaves the same result as a single-edge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| wipe_n | input | 1 | Active-low clear; asserts asynchronously, releases synchronously |
| sel_n | input | 1 | Active-low select for staging writes |
| wstb_n | input | 1 | Active-low write strobe |
| xfer_n | input | 1 | Active-low transfer strobe, staging to output |
| addr | input | 2 | Target select: bit 1 picks the channel, bit 0 picks the high nibble |
| bus | input | 8 | Write data |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| out_changed | output | 1 | One-cycle pulse on each new output value |

## Verification
The bench targets four corner cases:
- **High-nibble write with junk in bus bits 7..4.** A design that stored those bits would show a wrong code after the next transfer.
- **Transfer with select released, and transfer with write in flight.** A design that mixed these up would either update only one channel, or lag the transparent byte by a cycle.
- **Repeated transfer of an unchanged value.** This exposes a change pulse that fires on every transfer rather than on every real change.
- **Strobes held active across a wipe and its release.** This catches a clear that is only synchronous, or a release that lets a write through before the third edge.

A behavioural model, compared every cycle under long random traffic, covers the remaining orderings.

// File: rtl/twin_dac_pkg.sv
package twin_dac_pkg;
  localparam int LO_W        = 8;
  localparam int HI_W        = 4;
  localparam int CODE_W      = LO_W + HI_W;
  localparam int NCH         = 2;
  localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ADDR_W      = CH_W + 1;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/tdl_rst_sync.sv
module tdl_rst_sync #(
  parameter int STAGES = twin_dac_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic wipe_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr;

  // Asserts as soon as wipe_n falls; releases after STAGES rising edges.
  always_ff @(posedge clk or negedge wipe_n) begin
    if (!wipe_n) sr <= '0;
    else         sr <= {sr[STAGES-2:0], 1'b1};
  end

  assign rst_n = sr[STAGES-1];
endmodule

// File: rtl/tdl_decode.sv
module tdl_decode #(
  parameter int NCH    = twin_dac_pkg::NCH,
  parameter int CH_W   = twin_dac_pkg::CH_W,
  parameter int ADDR_W = twin_dac_pkg::ADDR_W
) (
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              xfer_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    wr_lo,
  output logic [NCH-1:0]    wr_hi,
  output logic              xfer
);
  logic load;

  assign load = !sel_n && !wstb_n;
  assign xfer = !xfer_n && !wstb_n;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit      = load && (addr[ADDR_W-1:1] == CH_W'(c));
    assign wr_lo[c] = hit && !addr[0];
    assign wr_hi[c] = hit &&  addr[0];
  end
endmodule

// File: rtl/tdl_chan.sv
module tdl_chan #(
  parameter int LO_W = twin_dac_pkg::LO_W,
  parameter int HI_W = twin_dac_pkg::HI_W,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              xfer,
  input  logic [LO_W-1:0]   din,
  output logic [CODE_W-1:0] code,
  output logic              changed
);
  logic [LO_W-1:0]   lo_q, lo_nx;
  logic [HI_W-1:0]   hi_q, hi_nx;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] staged_nx;
  logic              chg_q;

  always_comb begin
    lo_nx     = wr_lo ? din : lo_q;
    hi_nx     = wr_hi ? din[HI_W-1:0] : hi_q;
    staged_nx = {hi_nx, lo_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      code_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      lo_q  <= lo_nx;
      hi_q  <= hi_nx;
      if (xfer) code_q <= staged_nx;
      chg_q <= xfer && (staged_nx != code_q);
    end
  end

  assign code    = code_q;
  assign changed = chg_q;

  p_lo_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(din));
  p_hi_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> hi_q == $past(din[HI_W-1:0]));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi && !xfer) |=> ($stable(code_q) && $stable(lo_q) && $stable(hi_q)));
  p_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_lo && !wr_hi) |=> code_q == {hi_q, lo_q});
  p_transp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_lo) |=> code_q[LO_W-1:0] == $past(din));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q == (code_q != $past(code_q)));
endmodule

// File: rtl/twin_dac_loader.sv
module twin_dac_loader
  import twin_dac_pkg::*;
(
  input  logic              clk,
  input  logic              wipe_n,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              xfer_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LO_W-1:0]   bus,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              out_changed
);
  logic                  rst_n;
  logic [NCH-1:0]        wr_lo, wr_hi, chg;
  logic                  xfer;
  logic [CODE_W-1:0]     codes [NCH];

  tdl_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .wipe_n(wipe_n), .rst_n(rst_n)
  );

  tdl_decode #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .sel_n(sel_n), .wstb_n(wstb_n), .xfer_n(xfer_n), .addr(addr),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .xfer(xfer)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tdl_chan #(.LO_W(LO_W), .HI_W(HI_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]),
      .xfer(xfer), .din(bus), .code(codes[c]), .changed(chg[c])
    );
  end

  assign code_a      = codes[0];
  assign code_b      = codes[1];
  assign out_changed = |chg;

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_a == '0 && code_b == '0 && !out_changed));
endmodule

// File: tb/twin_dac_loader_tb.sv
module twin_dac_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        wipe_n = 1'b1;
  logic        sel_n = 1'b1, wstb_n = 1'b1, xfer_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  bus = '0;
  logic [11:0] code_a, code_b;
  logic        out_changed;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_lo[2], m_hi[2], m_out[2];
  int m_chg = 0, rel = 0;

  twin_dac_loader u_dut (
    .clk(clk), .wipe_n(wipe_n), .sel_n(sel_n), .wstb_n(wstb_n),
    .xfer_n(xfer_n), .addr(addr), .bus(bus),
    .code_a(code_a), .code_b(code_b), .out_changed(out_changed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_hi[c] = 0; m_out[c] = 0; end
  end

  always @(posedge clk or negedge wipe_n) begin
    if (!wipe_n) begin
      for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_hi[c] = 0; m_out[c] = 0; end
      m_chg = 0; rel = 0;
    end else if (rel < 2) begin
      rel++; m_chg = 0;
    end else begin
      int ch;
      ch = int'(addr[1]);
      m_chg = 0;
      if (!sel_n && !wstb_n) begin
        if (addr[0]) m_hi[ch] = int'(bus) % 16;
        else         m_lo[ch] = int'(bus);
      end
      if (!xfer_n && !wstb_n) begin
        for (int c = 0; c < 2; c++) begin
          int nv;
          nv = m_hi[c] * 256 + m_lo[c];
          if (nv != m_out[c]) m_chg = 1;
          m_out[c] = nv;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!done) begin
      chk("R3/R4/R6 model code_a", 32'(code_a), 32'(m_out[0]));
      chk("R3/R4/R6 model code_b", 32'(code_b), 32'(m_out[1]));
      chk("R8 model out_changed", 32'(out_changed), 32'(m_chg));
    end
  end

  task automatic drv(input logic s, input logic w, input logic x,
                     input logic [1:0] a, input logic [7:0] d);
    sel_n = s; wstb_n = w; xfer_n = x; addr = a; bus = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #1 wipe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 reset code_a", 32'(code_a), 0);
    chk("R5 reset code_b", 32'(code_b), 0);
    chk("R5 reset pulse", 32'(out_changed), 0);
    wipe_n = 1'b1;
    repeat (3) @(negedge clk);

    // stage both channels; high nibble carries junk in bits 7..4
    drv(0, 0, 1, 2'b00, 8'hA5); @(negedge clk);
    drv(0, 0, 1, 2'b01, 8'hF3); @(negedge clk);
    drv(0, 0, 1, 2'b10, 8'h3C); @(negedge clk);
    drv(0, 0, 1, 2'b11, 8'h97); @(negedge clk);
    drv(1, 1, 1, 2'b00, 8'h00); @(negedge clk);
    chk("R2 staged only code_a", 32'(code_a), 0);
    chk("R2 staged only code_b", 32'(code_b), 0);

    drv(1, 0, 0, 2'b00, 8'h00); @(negedge clk);
    chk("R3 R7 update code_a", 32'(code_a), 32'h3A5);
    chk("R3 R1 update code_b", 32'(code_b), 32'h73C);
    chk("R8 pulse on change", 32'(out_changed), 1);
    drv(1, 1, 1, 2'b00, 8'h00); @(negedge clk);
    chk("R8 pulse one cycle", 32'(out_changed), 0);
    drv(1, 0, 0, 2'b00, 8'h00); @(negedge clk);
    chk("R8 no pulse same value", 32'(out_changed), 0);

    drv(0, 0, 0, 2'b01, 8'h0E); @(negedge clk);
    chk("R4 transparent code_a", 32'(code_a), 32'hEA5);
    chk("R1 other channel kept", 32'(code_b), 32'h73C);
    drv(1, 1, 1, 2'b00, 8'h00); @(negedge clk);

    drv(0, 0, 1, 2'b10, 8'h11); repeat (3) @(negedge clk);
    drv(1, 1, 1, 2'b00, 8'h00); @(negedge clk);
    chk("R2 held write not output", 32'(code_b), 32'h73C);
    drv(1, 0, 0, 2'b00, 8'h00); @(negedge clk);
    chk("R9 held write result", 32'(code_b), 32'h711);
    chk("R9 channel a kept", 32'(code_a), 32'hEA5);

    drv(0, 1, 0, 2'b00, 8'hFF); repeat (2) @(negedge clk);
    drv(1, 0, 1, 2'b00, 8'hFF); @(negedge clk);
    drv(1, 0, 0, 2'b00, 8'h00); @(negedge clk);
    chk("R6 ignored strobes", 32'(code_a), 32'hEA5);

    drv(0, 0, 0, 2'b00, 8'h77);
    wipe_n = 1'b0;
    #1;
    chk("R5 async clear a", 32'(code_a), 0);
    chk("R5 async clear b", 32'(code_b), 0);
    @(negedge clk); @(negedge clk);
    chk("R5 clear overrides strobes", 32'(code_a), 0);
    wipe_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 two edges ignored", 32'(code_a), 0);
    @(negedge clk);
    chk("R5 third edge loads", 32'(code_a), 32'h077);
    drv(1, 1, 1, 2'b00, 8'h00); @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      drv(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0 ? 1 : 0),
          1'($urandom_range(0, 1)), 2'($urandom), 8'($urandom));
      if ($urandom_range(0, 99) == 0) wipe_n = ~wipe_n;
      else if (!wipe_n && $urandom_range(0, 3) == 0) wipe_n = 1'b1;
      @(negedge clk);
    end
    wipe_n = 1'b1;
    drv(1, 1, 1, 2'b00, 8'h00);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule